// File: doc/BRIEF.md
# Interrupt Priority Controller

This block gathers a vector of level-sensitive interrupt requests, a set of fixed-priority exception traps and one separately masked high-priority request. It then offers one winning vector address to each of two consumers: the main CPU and a secondary coprocessor. Software gives each request a priority level from 1 to 7 through a small write port, and a routing bit chooses which consumer handles it. Level 0 turns the request off.

Each consumer has a vector channel made of a valid, an acknowledge and a 16-bit vector. A channel raises valid one clock after it sees an eligible request. Valid then stays high until the consumer acknowledges it. While the channel waits, the vector keeps following the current winner. If every eligible request goes away before the acknowledge, the channel shows the spurious vector. A taken acknowledge drops valid for one cycle, so the controller can re-arbitrate against the new level in service.

The CPU side nests by level. An acknowledge saves the current level on an internal stack and raises the level to the one granted. A return input restores the saved level. The coprocessor side allows one level of nesting and no more.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, both valid outputs are low, `cpu_level` is 0, every request's level is 0 and every request is routed to the CPU.
- R2: A request whose level is 0 is never offered on either channel.
- R3: Among eligible maskable requests on a channel, the highest level wins, and on equal levels the lower index wins. The vector for request n is `vec_base + 2*n`.
- R4: A CPU-routed request is eligible only if its level is strictly greater than `cpu_level`. An acknowledge of a maskable grant sets `cpu_level` to the granted level. `cpu_rti` restores the previously saved level, and it is ignored when nothing is saved.
- R5: While `cpu_i_mask` is 1, no maskable request reaches the CPU channel. Traps are unaffected by this mask.
- R6: Traps beat everything else on the CPU channel, and the lowest set bit of `trap_req` wins. Trap bit k has vector 0xFFF8 - 2k. Bit 0 is the unimplemented-opcode trap, bit 1 the software interrupt, bit 2 the system call, and bits 3 to 5 the three access-violation traps. Acknowledging a trap sets `cpu_level` to 7.
- R7: `xirq_req` ranks below the traps and above all maskable requests. It uses vector 0xFFEA, is blocked while `cpu_x_mask` is 1, and sets `cpu_level` to 7 when acknowledged.
- R8: A request whose routing bit is 1 is offered only on the coprocessor channel, and one whose routing bit is 0 only on the CPU channel. A configuration write takes effect on the next clock.
- R9: On the coprocessor channel, a first grant is taken at any nonzero level. One nested grant is allowed if its level is strictly greater than the level in service. While two grants are active, nothing further is offered until `cop_done` releases one, and `cop_done` then restores the previous level.
- R10: Valid rises on the clock after an eligible request is sampled. It stays high until acknowledged. If the eligible requests vanish before the acknowledge, the vector becomes the spurious vector 0xFFE8, and acknowledging a spurious vector changes no level.
- R11: On the clock after an acknowledge is taken, that channel's valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one request's settings |
| cfg_idx | input | IDX_W | Request index to write |
| cfg_level | input | 3 | Priority level, 0 means disabled |
| cfg_to_cop | input | 1 | Routing bit, 1 means coprocessor |
| vec_base | input | 16 | Base address of the maskable vector table |
| irq_req | input | NUM_REQ | Level-sensitive maskable requests |
| trap_req | input | 6 | Non-maskable traps, bit 0 highest |
| xirq_req | input | 1 | Separately masked high-priority request |
| cpu_x_mask | input | 1 | Blocks `xirq_req` when 1 |
| cpu_i_mask | input | 1 | Blocks maskable CPU requests when 1 |
| cpu_vec_valid | output | 1 | CPU vector offered |
| cpu_vec_ack | input | 1 | CPU takes the offered vector |
| cpu_vec | output | 16 | CPU vector address |
| cpu_rti | input | 1 | CPU returns from the current handler |
| cpu_level | output | 3 | Level currently in service on the CPU |
| cop_vec_valid | output | 1 | Coprocessor vector offered |
| cop_vec_ack | input | 1 | Coprocessor takes the offered vector |
| cop_vec | output | 16 | Coprocessor vector address |
| cop_done | input | 1 | Coprocessor finishes its current handler |

## Verification
Every output comes from a register, so the effect of a request, mask, configuration write, acknowledge, return or done applied before a clock edge shows up right after that edge. `cpu_level` and the nesting state change on the same edge as the acknowledge. The re-arbitrated vector, computed against the new level, appears one edge later. The bench drives inputs on the falling edge and advances a reference model by one cycle for each rising edge. It compares valid, vector and level at the next falling edge, so every expected value lines up with the edge that produced it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W     = 3;
  localparam int VEC_W     = 16;
  localparam int NUM_TRAPS = 6;
  localparam int TOP_LVL   = 7;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [1:0] {
    GK_SPUR  = 2'd0,
    GK_FIXED = 2'd1,
    GK_MASK  = 2'd2
  } gkind_e;

  localparam vec_t TRAP_VEC_TOP = 16'hFFF8;
  localparam vec_t XIRQ_VEC     = 16'hFFEA;
  localparam vec_t SPUR_VEC     = 16'hFFE8;

  function automatic vec_t trap_vec(input int k);
    return TRAP_VEC_TOP - vec_t'(2 * k);
  endfunction
endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_prio_pkg::*;
#(
  parameter int NUM_REQ = 16,
  parameter int IDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  lvl_t                      wr_lvl,
  input  logic                      wr_cop,
  output lvl_t [NUM_REQ-1:0]        lvl_o,
  output logic [NUM_REQ-1:0]        cop_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o <= '0;
      cop_o <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          lvl_o[i] <= wr_lvl;
          cop_o[i] <= wr_cop;
        end
      end
    end
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_prio_pkg::*;
#(
  parameter int NUM_REQ = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_REQ-1:0] elig_i,
  input  lvl_t [NUM_REQ-1:0] lvl_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o,
  output lvl_t               lvl_o
);
  // Strict compare while scanning upward keeps the lowest index on ties.
  always_comb begin
    lvl_t best;
    best    = '0;
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (elig_i[i] && (lvl_i[i] > best)) begin
        best    = lvl_i[i];
        idx_o   = IDX_W'(i);
        found_o = 1'b1;
      end
    end
    lvl_o = best;
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH = 7,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == cnt_q) mem_q[i] <= data_i;
      end
      cnt_q <= cnt_q + CW'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i + 1) == cnt_q) top_o = mem_q[i];
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_REQ  = 16,
  parameter int IDX_W    = $clog2(NUM_REQ),
  parameter int CPU_NEST = 7,
  parameter int COP_NEST = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [LVL_W-1:0]     cfg_level,
  input  logic                 cfg_to_cop,
  input  logic [VEC_W-1:0]     vec_base,
  input  logic [NUM_REQ-1:0]   irq_req,
  input  logic [NUM_TRAPS-1:0] trap_req,
  input  logic                 xirq_req,
  input  logic                 cpu_x_mask,
  input  logic                 cpu_i_mask,
  output logic                 cpu_vec_valid,
  input  logic                 cpu_vec_ack,
  output logic [VEC_W-1:0]     cpu_vec,
  input  logic                 cpu_rti,
  output logic [LVL_W-1:0]     cpu_level,
  output logic                 cop_vec_valid,
  input  logic                 cop_vec_ack,
  output logic [VEC_W-1:0]     cop_vec,
  input  logic                 cop_done
);
  localparam int TRAP_IW = $clog2(NUM_TRAPS);

  // ---------------- configuration ----------------
  lvl_t [NUM_REQ-1:0] req_lvl;
  logic [NUM_REQ-1:0] req_cop;

  irq_cfg_bank #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_lvl(cfg_level), .wr_cop(cfg_to_cop),
    .lvl_o(req_lvl), .cop_o(req_cop)
  );

  // ---------------- CPU channel ----------------
  lvl_t               cpu_lvl_q;
  lvl_t               cpu_glvl_q;
  gkind_e             cpu_gkind_q;
  logic [NUM_REQ-1:0] cpu_elig;
  logic               c_found;
  logic [IDX_W-1:0]   c_idx;
  lvl_t               c_lvl;
  logic               t_hit;
  logic [TRAP_IW-1:0] t_idx;
  logic               c_any;
  vec_t               c_vec_n;
  lvl_t               c_lvl_n;
  gkind_e             c_kind_n;
  logic               cpu_fire;
  logic               cpu_push;
  lvl_t               cpu_saved;
  logic               cpu_stk_empty;
  logic               cpu_stk_full;

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      cpu_elig[i] = irq_req[i] && !req_cop[i] && !cpu_i_mask &&
                    (req_lvl[i] > cpu_lvl_q);
    end
  end

  irq_level_arb #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_cpu_arb (
    .elig_i(cpu_elig), .lvl_i(req_lvl),
    .found_o(c_found), .idx_o(c_idx), .lvl_o(c_lvl)
  );

  always_comb begin
    t_hit = 1'b0;
    t_idx = '0;
    for (int k = NUM_TRAPS - 1; k >= 0; k--) begin
      if (trap_req[k]) begin
        t_hit = 1'b1;
        t_idx = TRAP_IW'(k);
      end
    end
  end

  always_comb begin
    c_any    = 1'b1;
    c_vec_n  = SPUR_VEC;
    c_lvl_n  = '0;
    c_kind_n = GK_SPUR;
    if (t_hit) begin
      c_vec_n  = trap_vec(int'(t_idx));
      c_lvl_n  = lvl_t'(TOP_LVL);
      c_kind_n = GK_FIXED;
    end else if (xirq_req && !cpu_x_mask) begin
      c_vec_n  = XIRQ_VEC;
      c_lvl_n  = lvl_t'(TOP_LVL);
      c_kind_n = GK_FIXED;
    end else if (c_found) begin
      c_vec_n  = vec_base + vec_t'({c_idx, 1'b0});
      c_lvl_n  = c_lvl;
      c_kind_n = GK_MASK;
    end else begin
      c_any    = 1'b0;
    end
  end

  assign cpu_fire = cpu_vec_valid && cpu_vec_ack;
  assign cpu_push = cpu_fire && (cpu_gkind_q != GK_SPUR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_vec_valid <= 1'b0;
      cpu_vec       <= SPUR_VEC;
      cpu_glvl_q    <= '0;
      cpu_gkind_q   <= GK_SPUR;
    end else if (cpu_fire) begin
      cpu_vec_valid <= 1'b0;
    end else begin
      cpu_vec_valid <= cpu_vec_valid || c_any;
      cpu_vec       <= c_vec_n;
      cpu_glvl_q    <= c_lvl_n;
      cpu_gkind_q   <= c_kind_n;
    end
  end

  irq_nest_stack #(.DEPTH(CPU_NEST), .W(LVL_W)) u_cpu_stk (
    .clk(clk), .rst_n(rst_n),
    .push_i(cpu_push), .pop_i(cpu_rti && !cpu_push), .data_i(cpu_lvl_q),
    .top_o(cpu_saved), .empty_o(cpu_stk_empty), .full_o(cpu_stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_lvl_q <= '0;
    else if (cpu_push) cpu_lvl_q <= cpu_glvl_q;
    else if (cpu_rti && !cpu_stk_empty) cpu_lvl_q <= cpu_saved;
  end

  assign cpu_level = cpu_lvl_q;

  // ---------------- coprocessor channel ----------------
  lvl_t               cop_lvl_q;
  lvl_t               cop_glvl_q;
  logic               cop_spur_q;
  logic [NUM_REQ-1:0] cop_elig;
  logic               k_found;
  logic [IDX_W-1:0]   k_idx;
  lvl_t               k_lvl;
  logic               cop_fire;
  logic               cop_push;
  lvl_t               cop_saved;
  logic               cop_stk_empty;
  logic               cop_stk_full;

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      cop_elig[i] = irq_req[i] && req_cop[i] && (req_lvl[i] != '0) &&
                    !cop_stk_full && (cop_stk_empty || (req_lvl[i] > cop_lvl_q));
    end
  end

  irq_level_arb #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_cop_arb (
    .elig_i(cop_elig), .lvl_i(req_lvl),
    .found_o(k_found), .idx_o(k_idx), .lvl_o(k_lvl)
  );

  assign cop_fire = cop_vec_valid && cop_vec_ack;
  assign cop_push = cop_fire && !cop_spur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cop_vec_valid <= 1'b0;
      cop_vec       <= SPUR_VEC;
      cop_glvl_q    <= '0;
      cop_spur_q    <= 1'b1;
    end else if (cop_fire) begin
      cop_vec_valid <= 1'b0;
    end else begin
      cop_vec_valid <= cop_vec_valid || k_found;
      cop_vec       <= k_found ? (vec_base + vec_t'({k_idx, 1'b0})) : SPUR_VEC;
      cop_glvl_q    <= k_lvl;
      cop_spur_q    <= !k_found;
    end
  end

  irq_nest_stack #(.DEPTH(COP_NEST), .W(LVL_W)) u_cop_stk (
    .clk(clk), .rst_n(rst_n),
    .push_i(cop_push), .pop_i(cop_done && !cop_push), .data_i(cop_lvl_q),
    .top_o(cop_saved), .empty_o(cop_stk_empty), .full_o(cop_stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cop_lvl_q <= '0;
    else if (cop_push) cop_lvl_q <= cop_glvl_q;
    else if (cop_done && !cop_stk_empty) cop_lvl_q <= cop_saved;
  end

  // ---------------- assertions ----------------
  AST_CPU_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_vec_valid && !cpu_vec_ack |=> cpu_vec_valid); // R10
  AST_CPU_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_vec_valid && cpu_vec_ack |=> !cpu_vec_valid); // R11
  AST_COP_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cop_vec_valid && cop_vec_ack |=> !cop_vec_valid); // R11
  AST_CPU_LEVEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_vec_valid && cpu_vec_ack && (cpu_gkind_q == GK_MASK)
    |=> cpu_level > $past(cpu_level)); // R4
  AST_IMASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_i_mask && (trap_req == '0) && !(xirq_req && !cpu_x_mask) && !cpu_vec_valid
    |=> !cpu_vec_valid); // R5
  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req[0] && !cpu_fire |=> cpu_vec_valid && (cpu_vec == TRAP_VEC_TOP)); // R6
  AST_COP_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cop_stk_full |-> !cop_vec_valid); // R9
  AST_COP_LEVEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cop_push |=> cop_lvl_q > $past(cop_lvl_q)); // R9
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cfg_we = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [2:0]    cfg_level = '0;
  logic          cfg_to_cop = 0;
  logic [15:0]   vec_base = 16'h8000;
  logic [N-1:0]  irq_req = '0;
  logic [5:0]    trap_req = '0;
  logic          xirq_req = 0, cpu_x_mask = 0, cpu_i_mask = 0;
  logic          cpu_vec_ack = 0, cpu_rti = 0, cop_vec_ack = 0, cop_done = 0;
  logic          cpu_vec_valid, cop_vec_valid;
  logic [15:0]   cpu_vec, cop_vec;
  logic [2:0]    cpu_level;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_level(cfg_level), .cfg_to_cop(cfg_to_cop),
    .vec_base(vec_base), .irq_req(irq_req), .trap_req(trap_req),
    .xirq_req(xirq_req), .cpu_x_mask(cpu_x_mask), .cpu_i_mask(cpu_i_mask),
    .cpu_vec_valid(cpu_vec_valid), .cpu_vec_ack(cpu_vec_ack), .cpu_vec(cpu_vec),
    .cpu_rti(cpu_rti), .cpu_level(cpu_level),
    .cop_vec_valid(cop_vec_valid), .cop_vec_ack(cop_vec_ack), .cop_vec(cop_vec),
    .cop_done(cop_done)
  );

  // reference model state
  int m_lvl [N];
  bit m_cop [N];
  int cstk [7];
  int ccnt = 0, clvl = 0;
  int kstk [2];
  int kcnt = 0, klvl = 0;
  bit e_cv = 0; logic [15:0] e_cvec = 16'hFFE8; int e_cgl = 0, e_ckind = 0;
  bit e_kv = 0; logic [15:0] e_kvec = 16'hFFE8; int e_kgl = 0; bit e_kspur = 1;
  int checks = 0, fails = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string pick_tag(string tag, string dflt);
    return (tag == "") ? dflt : tag;
  endfunction

  function automatic void cpu_pick(output bit any, output logic [15:0] v,
                                   output int gl, output int kind);
    int best, bi;
    any = 0; v = 16'hFFE8; gl = 0; kind = 0; best = 0; bi = 0;
    for (int k = 5; k >= 0; k--)
      if (trap_req[k]) begin any = 1; v = 16'hFFF8 - 16'(2 * k); gl = 7; kind = 1; end
    if (!any && xirq_req && !cpu_x_mask) begin any = 1; v = 16'hFFEA; gl = 7; kind = 1; end
    if (!any && !cpu_i_mask) begin
      for (int i = 0; i < N; i++)
        if (irq_req[i] && !m_cop[i] && m_lvl[i] > best && m_lvl[i] > clvl) begin
          best = m_lvl[i]; bi = i;
        end
      if (best > 0) begin any = 1; v = vec_base + 16'(2 * bi); gl = best; kind = 2; end
    end
  endfunction

  function automatic void cop_pick(output bit any, output logic [15:0] v, output int gl);
    int best, bi;
    any = 0; v = 16'hFFE8; gl = 0; best = 0; bi = 0;
    if (kcnt < 2) begin
      for (int i = 0; i < N; i++)
        if (irq_req[i] && m_cop[i] && m_lvl[i] > best && (kcnt == 0 || m_lvl[i] > klvl)) begin
          best = m_lvl[i]; bi = i;
        end
      if (best > 0) begin any = 1; v = vec_base + 16'(2 * bi); gl = best; end
    end
  endfunction

  // One clock: model advances from inputs at the rising edge, outputs checked at the falling edge.
  task automatic cycle(string tag);
    bit ca, ka, cfire, kfire;
    logic [15:0] cv, kv;
    int cgl, ckind, kgl;
    cpu_pick(ca, cv, cgl, ckind);
    cop_pick(ka, kv, kgl);
    cfire = e_cv && cpu_vec_ack;
    kfire = e_kv && cop_vec_ack;
    if (cfire && e_ckind != 0) begin
      if (ccnt < 7) begin cstk[ccnt] = clvl; ccnt++; end
      clvl = e_cgl;
    end else if (cpu_rti && ccnt > 0) begin
      ccnt--; clvl = cstk[ccnt];
    end
    if (cfire) e_cv = 0;
    else begin e_cv = e_cv | ca; e_cvec = cv; e_cgl = cgl; e_ckind = ckind; end
    if (kfire && !e_kspur) begin
      kstk[kcnt] = klvl; kcnt++; klvl = e_kgl;
    end else if (cop_done && kcnt > 0) begin
      kcnt--; klvl = kstk[kcnt];
    end
    if (kfire) e_kv = 0;
    else begin e_kv = e_kv | ka; e_kvec = kv; e_kgl = kgl; e_kspur = !ka; end
    if (cfg_we) begin m_lvl[cfg_idx] = int'(cfg_level); m_cop[cfg_idx] = cfg_to_cop; end
    @(posedge clk);
    @(negedge clk);
    chk(pick_tag(tag, "R10"), "cpu valid", 32'(cpu_vec_valid), 32'(e_cv));
    if (e_cv)
      chk(pick_tag(tag, (e_ckind == 1) ? "R6" : (e_ckind == 2) ? "R3" : "R10"),
          "cpu vec", 32'(cpu_vec), 32'(e_cvec));
    chk(pick_tag(tag, "R4"), "cpu level", 32'(cpu_level), 32'(clvl));
    chk(pick_tag(tag, "R8"), "cop valid", 32'(cop_vec_valid), 32'(e_kv));
    if (e_kv) chk(pick_tag(tag, "R9"), "cop vec", 32'(cop_vec), 32'(e_kvec));
  endtask

  task automatic cfgw(int idx, int lvl, bit cop);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_level = 3'(lvl); cfg_to_cop = cop;
    cycle("R8");
    cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd9157));
    for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_cop[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "cpu valid", 32'(cpu_vec_valid), 0);
    chk("R1", "cop valid", 32'(cop_vec_valid), 0);
    chk("R1", "cpu level", 32'(cpu_level), 0);
    irq_req = '1;
    cycle("R1");              // all levels still 0 after reset
    irq_req = '0;
    cycle("R1");

    for (int i = 0; i < N; i++) cfgw(i, i % 8, (i % 5) == 4);

    // R2: level-0 requests are never offered
    irq_req = 16'h0101;
    cycle("R2"); cycle("R2");
    irq_req = '0;

    // R3: equal levels pick lower index, higher level overtakes
    irq_req = 16'h0808;       // req3 and req11, both level 3
    cycle("R3"); cycle("R3");
    irq_req = 16'h0828;       // add req5, level 5
    cycle("R3");
    cpu_vec_ack = 1; cycle("R11"); cpu_vec_ack = 0;
    cycle("R4"); cycle("R4"); // nothing above level 5 pending
    irq_req = 16'h08A8;       // add req7, level 7
    cycle("R4");
    irq_req = 16'h0828;       // withdraw before ack
    cycle("R10");
    cpu_vec_ack = 1; cycle("R10"); cpu_vec_ack = 0;
    cpu_rti = 1; cycle("R4"); cpu_rti = 0;
    cycle("R4");
    irq_req = '0;
    cpu_vec_ack = 1; cycle("R11"); cpu_vec_ack = 0;
    cpu_rti = 1; cycle("R4"); cycle("R4"); cpu_rti = 0;

    // R5: I mask blocks maskable requests but not traps
    cpu_i_mask = 1; irq_req = 16'h0080;
    cycle("R5"); cycle("R5");
    trap_req = 6'b000100; cycle("R6");
    trap_req = 6'b000101; cycle("R6");
    cpu_vec_ack = 1; cycle("R6"); cpu_vec_ack = 0;
    trap_req = '0; cpu_rti = 1; cycle("R6"); cpu_rti = 0;
    cpu_i_mask = 0; irq_req = '0;
    cycle("R5");

    // R7: xirq gated by its mask, ranked below traps
    xirq_req = 1; cpu_x_mask = 1; irq_req = 16'h0080;
    cycle("R7"); cycle("R7");
    cpu_x_mask = 0; cycle("R7");
    trap_req = 6'b000010; cycle("R7");
    trap_req = '0; cycle("R7");
    cpu_vec_ack = 1; cycle("R7"); cpu_vec_ack = 0;
    xirq_req = 0; irq_req = '0;
    cpu_rti = 1; cycle("R7"); cpu_rti = 0;
    cpu_vec_ack = 1; cycle("R7"); cpu_vec_ack = 0;
    cycle("R7");

    // R8/R9: coprocessor routing and one-deep nesting
    irq_req = 16'h0010;       // req4, level 4, routed to coprocessor
    cycle("R8"); cycle("R8");
    cop_vec_ack = 1; cycle("R9"); cop_vec_ack = 0;
    irq_req = 16'h4210;       // req14 level 6, req9 level 1
    cycle("R9");
    cop_vec_ack = 1; cycle("R9"); cop_vec_ack = 0;
    cycle("R9"); cycle("R9"); // two active, nothing offered
    cop_done = 1; cycle("R9"); cop_done = 0;
    cycle("R9"); cycle("R9");
    irq_req = '0;
    cop_vec_ack = 1; cycle("R9"); cop_vec_ack = 0;
    cop_done = 1; cycle("R9"); cycle("R9"); cycle("R9"); cop_done = 0;
    cycle("R9");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      irq_req     = N'($urandom) & N'($urandom) & N'($urandom);
      trap_req    = ($urandom % 40 == 0) ? 6'($urandom) : 6'd0;
      xirq_req    = ($urandom % 16 == 0);
      cpu_x_mask  = $urandom % 2;
      cpu_i_mask  = ($urandom % 8 == 0);
      cpu_vec_ack = $urandom % 2;
      cop_vec_ack = $urandom % 2;
      cpu_rti     = ($urandom % 5 == 0);
      cop_done    = ($urandom % 5 == 0);
      cfg_we      = ($urandom % 20 == 0);
      cfg_idx     = IW'($urandom);
      cfg_level   = 3'($urandom);
      cfg_to_cop  = $urandom % 2;
      cycle("");
    end
    finish_run();
  end
endmodule